// File: doc/BRIEF.md
# Warp Issue Sequencer

This block feeds a group of SIMD lanes from a pool of resident warp contexts. Each context holds a program counter, a 32-bit active-thread mask and a flag that says whether the warp is stalled on memory. Time is cut into slots of four clocks. In each slot one warp instruction is sent to the lanes, eight threads per clock. The sequencer drives a valid bit and a thread index to every lane, together with the warp number, its PC and the slice number.

At the last clock of each slot, a round-robin picker chooses the next warp among those that are resident and not stalled. Because the warp can change at every slot, a warp that waits on memory costs no issue slots as long as any other warp can run. Warps are loaded by a launch port. A stall port parks a warp, and a wake port frees it again when its memory access completes.

Top module: `warp_issue_seq`

## Requirements
- R1: After reset no warp is resident: `slot_valid` is 0, every `lane_valid` bit is 0 and `issue_slice` is 0.
- R2: `issue_slice` counts 0, 1, 2, 3, 0, ... without pause. `issue_wid` and `slot_valid` change only on the edge that ends slice 3.
- R3: At the edge that ends slice 3, the next warp is the first ready warp found by searching upward from the previously issued warp plus one, wrapping at 24. The search starts at warp 0 after reset.
- R4: During slice s of a valid slot, `lane_valid[l]` equals bit s*8+l of the issued warp's active mask.
- R5: The thread index of lane l sits in `lane_tid[l*5 +: 5]` and equals s*8+l, where s is the current slice.
- R6: `issue_pc` shows the issued warp's PC for the whole slot. That PC goes up by 1 on the edge that ends the slot.
- R7: A warp named on the stall port is skipped by selection until the wake port names it. If stall and wake name the same warp in the same cycle, the stall wins. Port events take effect from the edge that samples them, so a selection on that same edge still uses the old state.
- R8: When no warp is ready at a slot boundary, the following 4-cycle slot has `slot_valid` 0 and all `lane_valid` bits 0.
- R9: A launch loads the PC and mask of the named warp and makes it resident and ready. It overrides a same-cycle stall, wake or PC advance of that warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_en | input | 1 | Load a warp context |
| launch_wid | input | 5 | Warp being loaded |
| launch_pc | input | 16 | Start PC |
| launch_mask | input | 32 | Active-thread mask |
| stall_en | input | 1 | Park a warp on memory |
| stall_wid | input | 5 | Warp to park |
| wake_en | input | 1 | Memory completion |
| wake_wid | input | 5 | Warp whose access completed |
| slot_valid | output | 1 | Current slot carries a warp instruction |
| issue_wid | output | 5 | Warp being issued |
| issue_pc | output | 16 | PC of that warp |
| issue_slice | output | 2 | Slice number inside the slot |
| lane_valid | output | 8 | Per-lane execute enable |
| lane_tid | output | 40 | Per-lane thread index, 5 bits per lane |

## Verification
The assertions assume that every warp number on the three ports is below 24. They also assume that launch and stall never name the same warp in the same cycle. The bench draws all of its warp numbers modulo 24 and drops a stall whenever a launch names the same warp. A reference model in the bench tracks residency, stalls, PCs and masks, and is compared with the outputs every cycle. The stimulus covers directed phases (wrap-around, all warps stalled, and stall and wake in the same cycle) and a long pseudo-random phase.

// File: rtl/wis_pkg.sv
package wis_pkg;
    // Adds an offset to a warp index and wraps once at n.
    function automatic int wrap_add(int base, int off, int n);
        int s;
        s = base + off;
        return (s >= n) ? s - n : s;
    endfunction
endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WARPS = 24,
    parameter int WID_W     = 5
) (
    input  logic [NUM_WARPS-1:0] ready_vec,
    input  logic [WID_W-1:0]     last_wid,
    output logic                 found,
    output logic [WID_W-1:0]     pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            int idx;
            idx = wis_pkg::wrap_add(int'(last_wid), k, NUM_WARPS);
            if (!found && ready_vec[idx]) begin
                found = 1'b1;
                pick  = WID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/wis_ctx_table.sv
module wis_ctx_table #(
    parameter int NUM_WARPS = 24,
    parameter int WARP_SIZE = 32,
    parameter int PC_W      = 16,
    parameter int WID_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_en,
    input  logic [WID_W-1:0]     launch_wid,
    input  logic [PC_W-1:0]      launch_pc,
    input  logic [WARP_SIZE-1:0] launch_mask,
    input  logic                 stall_en,
    input  logic [WID_W-1:0]     stall_wid,
    input  logic                 wake_en,
    input  logic [WID_W-1:0]     wake_wid,
    input  logic                 adv_en,
    input  logic [WID_W-1:0]     adv_wid,
    input  logic [WID_W-1:0]     rd_wid,
    output logic [NUM_WARPS-1:0] ready_vec,
    output logic [PC_W-1:0]      rd_pc,
    output logic [WARP_SIZE-1:0] rd_mask
);
    typedef struct packed {
        logic [NUM_WARPS-1:0][PC_W-1:0]      pc;
        logic [NUM_WARPS-1:0][WARP_SIZE-1:0] mask;
        logic [NUM_WARPS-1:0]                resident;
        logic [NUM_WARPS-1:0]                waiting;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (adv_en)
            tbl_d.pc[adv_wid] = tbl_q.pc[adv_wid] + PC_W'(1);
        if (wake_en)
            tbl_d.waiting[wake_wid] = 1'b0;
        if (stall_en)
            tbl_d.waiting[stall_wid] = 1'b1;
        if (launch_en) begin
            tbl_d.pc[launch_wid]       = launch_pc;
            tbl_d.mask[launch_wid]     = launch_mask;
            tbl_d.resident[launch_wid] = 1'b1;
            tbl_d.waiting[launch_wid]  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign ready_vec = tbl_q.resident & ~tbl_q.waiting;
    assign rd_pc     = tbl_q.pc[rd_wid];
    assign rd_mask   = tbl_q.mask[rd_wid];

    // R7: a stall without a same-warp launch leaves the warp not ready
    a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_en && !(launch_en && launch_wid == stall_wid))
        |=> !ready_vec[$past(stall_wid)]);

    // R9: a launch makes the warp ready with the loaded PC
    a_r9_launch_loads: assert property (@(posedge clk) disable iff (!rst_n)
        launch_en |=> (ready_vec[$past(launch_wid)] && tbl_q.pc[$past(launch_wid)] == $past(launch_pc)));
endmodule

// File: rtl/wis_lane_drive.sv
module wis_lane_drive #(
    parameter int WARP_SIZE = 32,
    parameter int NUM_LANES = 8,
    parameter int SL_W      = 2,
    parameter int TID_W     = 5
) (
    input  logic                       slot_valid,
    input  logic [SL_W-1:0]            slice,
    input  logic [WARP_SIZE-1:0]       mask,
    output logic [NUM_LANES-1:0]       lane_valid,
    output logic [NUM_LANES*TID_W-1:0] lane_tid
);
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [TID_W-1:0] tid;
        assign tid = TID_W'(int'(slice) * NUM_LANES + l);
        assign lane_tid[l*TID_W +: TID_W] = tid;
        assign lane_valid[l] = slot_valid & mask[tid];
    end
endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq #(
    parameter int NUM_WARPS = 24,
    parameter int WARP_SIZE = 32,
    parameter int NUM_LANES = 8,
    parameter int PC_W      = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              launch_en,
    input  logic [$clog2(NUM_WARPS)-1:0]      launch_wid,
    input  logic [PC_W-1:0]                   launch_pc,
    input  logic [WARP_SIZE-1:0]              launch_mask,
    input  logic                              stall_en,
    input  logic [$clog2(NUM_WARPS)-1:0]      stall_wid,
    input  logic                              wake_en,
    input  logic [$clog2(NUM_WARPS)-1:0]      wake_wid,
    output logic                              slot_valid,
    output logic [$clog2(NUM_WARPS)-1:0]      issue_wid,
    output logic [PC_W-1:0]                   issue_pc,
    output logic [$clog2(WARP_SIZE/NUM_LANES)-1:0] issue_slice,
    output logic [NUM_LANES-1:0]              lane_valid,
    output logic [NUM_LANES*$clog2(WARP_SIZE)-1:0] lane_tid
);
    localparam int WID_W  = $clog2(NUM_WARPS);
    localparam int SLICES = WARP_SIZE / NUM_LANES;
    localparam int SL_W   = $clog2(SLICES);
    localparam int TID_W  = $clog2(WARP_SIZE);

    typedef struct packed {
        logic             slot_valid;
        logic [WID_W-1:0] cur;
        logic [WID_W-1:0] last;
        logic [SL_W-1:0]  slice;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                 boundary;
    logic [NUM_WARPS-1:0] ready_vec;
    logic                 found;
    logic [WID_W-1:0]     pick;
    logic [PC_W-1:0]      cur_pc;
    logic [WARP_SIZE-1:0] cur_mask;

    assign boundary = (seq_q.slice == SL_W'(SLICES - 1));

    wis_ctx_table #(
        .NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE), .PC_W(PC_W), .WID_W(WID_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .launch_en(launch_en), .launch_wid(launch_wid),
        .launch_pc(launch_pc), .launch_mask(launch_mask),
        .stall_en(stall_en), .stall_wid(stall_wid),
        .wake_en(wake_en), .wake_wid(wake_wid),
        .adv_en(boundary && seq_q.slot_valid), .adv_wid(seq_q.cur),
        .rd_wid(seq_q.cur),
        .ready_vec(ready_vec), .rd_pc(cur_pc), .rd_mask(cur_mask)
    );

    wis_rr_pick #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_pick (
        .ready_vec(ready_vec), .last_wid(seq_q.last),
        .found(found), .pick(pick)
    );

    wis_lane_drive #(
        .WARP_SIZE(WARP_SIZE), .NUM_LANES(NUM_LANES), .SL_W(SL_W), .TID_W(TID_W)
    ) u_lanes (
        .slot_valid(seq_q.slot_valid), .slice(seq_q.slice), .mask(cur_mask),
        .lane_valid(lane_valid), .lane_tid(lane_tid)
    );

    always_comb begin
        seq_d = seq_q;
        if (boundary) begin
            seq_d.slice      = '0;
            seq_d.slot_valid = found;
            if (found) begin
                seq_d.cur  = pick;
                seq_d.last = pick;
            end
        end else begin
            seq_d.slice = seq_q.slice + SL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.slot_valid <= 1'b0;
            seq_q.cur        <= '0;
            seq_q.last       <= WID_W'(NUM_WARPS - 1);
            seq_q.slice      <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign slot_valid  = seq_q.slot_valid;
    assign issue_wid   = seq_q.cur;
    assign issue_pc    = cur_pc;
    assign issue_slice = seq_q.slice;

    // R2: slices advance by one and wrap after the last
    a_r2_slice_step: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> issue_slice == $past(issue_slice) + SL_W'(1));
    a_r2_slice_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> issue_slice == '0);
    // R2: warp choice holds inside a slot
    a_r2_wid_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(issue_wid) && $stable(slot_valid)));
    // R7: only a ready warp is ever picked
    a_r7_pick_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && found) |-> ready_vec[pick]);
    // R8: no ready warp gives an empty slot
    a_r8_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && ready_vec == '0) |=> (!slot_valid && lane_valid == '0));
    // R4: lanes stay quiet outside a valid slot
    a_r4_quiet_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |-> lane_valid == '0);
    // R6: PC advances by one across a completed slot of the same warp
    a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && slot_valid && found && pick == issue_wid && !launch_en)
        |=> issue_pc == $past(issue_pc) + PC_W'(1));
endmodule

// File: tb/warp_issue_seq_bench.sv
module warp_issue_seq_bench;
    localparam int PERIOD = 10;
    localparam int NW = 24;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        launch_en = 0;
    logic [4:0]  launch_wid = 0;
    logic [15:0] launch_pc = 0;
    logic [31:0] launch_mask = 0;
    logic        stall_en = 0;
    logic [4:0]  stall_wid = 0;
    logic        wake_en = 0;
    logic [4:0]  wake_wid = 0;
    logic        slot_valid;
    logic [4:0]  issue_wid;
    logic [15:0] issue_pc;
    logic [1:0]  issue_slice;
    logic [7:0]  lane_valid;
    logic [39:0] lane_tid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    warp_issue_seq u_warp_issue_seq (
        .clk(clk), .rst_n(rst_n),
        .launch_en(launch_en), .launch_wid(launch_wid),
        .launch_pc(launch_pc), .launch_mask(launch_mask),
        .stall_en(stall_en), .stall_wid(stall_wid),
        .wake_en(wake_en), .wake_wid(wake_wid),
        .slot_valid(slot_valid), .issue_wid(issue_wid), .issue_pc(issue_pc),
        .issue_slice(issue_slice), .lane_valid(lane_valid), .lane_tid(lane_tid)
    );

    // Reference model built from the requirements
    int        m_pc   [NW];
    bit [31:0] m_mask [NW];
    bit        m_res  [NW];
    bit        m_wait [NW];
    int        m_cur, m_last, m_slice;
    bit        m_sv;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) begin
                m_pc[i] = 0; m_mask[i] = 0; m_res[i] = 0; m_wait[i] = 0;
            end
            m_cur = 0; m_last = NW - 1; m_slice = 0; m_sv = 0;
        end else begin
            bit f; int p;
            f = 0; p = 0;
            if (m_slice == 3) begin
                for (int k = 1; k <= NW; k++) begin
                    int idx;
                    idx = (m_last + k) % NW;
                    if (!f && m_res[idx] && !m_wait[idx]) begin f = 1; p = idx; end
                end
                if (m_sv) m_pc[m_cur] = (m_pc[m_cur] + 1) % 65536;
            end
            if (wake_en)  m_wait[wake_wid] = 0;
            if (stall_en) m_wait[stall_wid] = 1;
            if (launch_en) begin
                m_pc[launch_wid] = launch_pc; m_mask[launch_wid] = launch_mask;
                m_res[launch_wid] = 1; m_wait[launch_wid] = 0;
            end
            if (m_slice == 3) begin
                m_slice = 0; m_sv = f;
                if (f) begin m_cur = p; m_last = p; end
            end else m_slice = m_slice + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit [7:0]  ev;
        bit [39:0] et;
        for (int l = 0; l < 8; l++) begin
            ev[l] = m_sv ? m_mask[m_cur][m_slice*8 + l] : 1'b0;
            et[l*5 +: 5] = 5'(m_slice*8 + l);
        end
        chk(slot_valid == m_sv, "R8 slot_valid", slot_valid, m_sv);
        chk(issue_slice == 2'(m_slice), "R2 issue_slice", issue_slice, m_slice);
        if (m_sv) begin
            chk(issue_wid == 5'(m_cur), "R3 R7 R9 issue_wid", issue_wid, m_cur);
            chk(issue_pc == 16'(m_pc[m_cur]), "R6 R9 issue_pc", issue_pc, m_pc[m_cur]);
        end
        chk(lane_valid == ev, "R4 lane_valid", lane_valid, ev);
        chk(lane_tid == et, "R5 lane_tid", int'(lane_tid[31:0]), int'(et[31:0]));
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        launch_en = 0; stall_en = 0; wake_en = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_launch(input int w, input int pc, input bit [31:0] m);
        launch_en = 1; launch_wid = 5'(w); launch_pc = 16'(pc); launch_mask = m;
        tick();
    endtask

    task automatic do_stall(input int w);
        stall_en = 1; stall_wid = 5'(w); tick();
    endtask

    task automatic do_wake(input int w);
        wake_en = 1; wake_wid = 5'(w); tick();
    endtask

    bit [31:0] lfsr = 32'h1234_5678;
    function automatic bit [31:0] nxt(input bit [31:0] x);
        bit [31:0] y;
        y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(slot_valid == 0, "R1 slot_valid", slot_valid, 0);
        chk(lane_valid == 0, "R1 lane_valid", lane_valid, 0);
        chk(issue_slice == 0, "R1 issue_slice", issue_slice, 0);
        rst_n = 1;
        run(8);                                   // R8: nothing resident
        do_launch(0, 16'h100, 32'hFFFF_FFFF);
        do_launch(1, 16'h200, 32'h0000_FFFF);
        do_launch(2, 16'h300, 32'hA5A5_A5A5);
        do_launch(3, 16'h400, 32'h0000_0001);
        do_launch(4, 16'h500, 32'h8000_0000);
        do_launch(5, 16'hFFFF, 32'h0F0F_00F0);     // R6: PC wraps
        run(40);                                   // R3 R4 R5 R6
        do_stall(1); do_stall(3);                  // R7
        run(30);
        do_wake(1);
        run(20);
        stall_en = 1; stall_wid = 0; wake_en = 1; wake_wid = 0; tick(); // R7 stall wins
        run(20);
        do_wake(0); do_wake(3);
        for (int w = 0; w < 6; w++) do_stall(w);   // R8: all parked
        run(16);
        do_wake(4);
        run(16);
        do_launch(4, 16'h0777, 32'h00FF_FF00);     // R9: relaunch a live warp
        run(12);
        do_launch(23, 16'h2300, 32'h1234_5678);    // R3: wrap-around
        do_launch(22, 16'h2200, 32'hFFFF_0000);
        run(60);
        for (int i = 0; i < 900; i++) begin        // mixed pseudo-random phase
            lfsr = nxt(lfsr);
            if (lfsr[3:0] == 0) begin
                launch_en = 1; launch_wid = 5'(lfsr[12:8] % NW);
                launch_pc = lfsr[31:16]; launch_mask = nxt(lfsr);
            end
            if (lfsr[6:4] == 0 && !(launch_en && launch_wid == 5'(lfsr[20:16] % NW))) begin
                stall_en = 1; stall_wid = 5'(lfsr[20:16] % NW);
            end
            if (lfsr[7] && lfsr[22:21] != 0) begin
                wake_en = 1; wake_wid = 5'(lfsr[29:25] % NW);
            end
            tick();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule